// File: doc/BRIEF.md
# Speculative Branch Dependency Tracker

This block keeps the branch-dependency bookkeeping for a pipeline that issues past up to four unresolved conditional branches. Each outstanding branch owns one bit of a small dependency mask. Every instruction that enters the in-flight table is stamped with the mask of the branches still open at that moment. Its results are therefore tied to the outcome of each of those branches.

When a branch is dispatched, the block hands it a free bit and remembers which older branches were open at that point. When the branch condition is known, the dispatch logic reports it. If the guess was right, the bit is wiped from every stored mask and the slot returns to the pool. If the guess was wrong, every table entry that carries the bit is aborted through a one-cycle kill vector, so its result is never written back. The slot of the failed branch is released, and so is the slot of every younger branch that was opened behind it. Only wrong-path work is cancelled, and the rest of the pipeline keeps running.

A registered read port returns the stored mask of any table entry. Dispatch uses it to inspect the table.

Top module: `spec_mask_tracker`

## Requirements
- R1: After reset, no branch slot is busy (`br_busy` = 0), no table entry is valid (`ent_valid` = 0), `kill_vec` is 0, and `br_gnt` is low while `br_req` is low.
- R2: A branch request is granted in the same cycle when a slot is free. `br_idx` gives the lowest-numbered free slot, with slot numbers in binary 0 to 3, and bit `br_idx` of `br_busy` is set from the next cycle.
- R3: With all four slots busy and no resolution in that cycle, `br_gnt` stays low (dispatch stall), and `br_busy` is unchanged.
- R4: `disp_mask` is combinationally equal to the busy slots minus any slot freed by a resolution in that same cycle. When `disp_valid` is high, that mask is stored in entry `disp_slot`. A slot granted in the same cycle is not included in that mask, and it is included in every later dispatch.
- R5: A correct resolution (`rsv_valid`, `rsv_wrong` = 0) of a busy slot clears that bit in every stored entry mask and in `br_busy` at the next edge. It raises no kill.
- R6: A wrong resolution of busy slot b sets `kill_vec[e]` high, for exactly one cycle starting the cycle after, for every valid entry e whose mask has bit b. In the same cycle those entries leave `ent_valid`, and the other entries stay valid.
- R7: A wrong resolution also frees every busy slot whose branch was granted while slot b was busy, so that its recorded older-branch set contains b.
- R8: A resolution is applied before an allocation in the same cycle. A slot freed by that resolution can be granted in the same cycle.
- R9: A resolution naming a slot that is not busy is ignored: no kill, no change to `br_busy` or to the stored masks.
- R10: `rel_valid` drops entry `rel_slot` from `ent_valid` at the next edge, and that entry is no longer killed later.
- R11: `rd_mask` returns, one edge after `rd_slot` is set, the mask stored in that entry before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_req | input | 1 | Request a slot for a dispatched branch |
| br_gnt | output | 1 | Slot granted this cycle |
| br_idx | output | 2 | Index of the granted slot |
| disp_valid | input | 1 | Write an instruction into the table |
| disp_slot | input | 3 | Table entry written |
| disp_mask | output | 4 | Dependency mask given to the instruction dispatched this cycle |
| rsv_valid | input | 1 | A branch resolves this cycle |
| rsv_idx | input | 2 | Slot of the resolving branch |
| rsv_wrong | input | 1 | 1 = mispredicted, 0 = predicted correctly |
| rel_valid | input | 1 | Release a table entry (it left the pipeline) |
| rel_slot | input | 3 | Entry released |
| kill_vec | output | 8 | Per-entry abort pulse |
| ent_valid | output | 8 | Per-entry valid flags |
| br_busy | output | 4 | Slots holding an unresolved branch |
| rd_slot | input | 3 | Entry whose mask is read |
| rd_mask | output | 4 | Registered mask of entry `rd_slot` |

## Verification
Grant, slot index and dispatch mask respond in the same cycle as their inputs. The bench drives the inputs one time unit after a rising edge and samples these outputs one further unit later, before the next edge. The busy set, valid flags, kill pulse and read data each pass through one register. They are sampled one unit after the edge that follows the stimulus, with the other inputs idle. The kill pulse is also checked to fall in the cycle after that. A mask read takes one more edge, so resolution effects are read back only after the resolving edge has passed.

// File: rtl/smt_pkg.sv
package smt_pkg;

  // Kind of branch outcome presented in one cycle
  typedef enum logic [1:0] {
    RSV_IDLE = 2'd0,
    RSV_HIT  = 2'd1,
    RSV_MISS = 2'd2
  } rsv_kind_e;

endpackage

// File: rtl/smt_prio_enc.sv
module smt_prio_enc #(
  parameter int W = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  // Lowest set bit wins
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/smt_slot_pool.sv
module smt_slot_pool
  import smt_pkg::*;
#(
  parameter int NUM_BR = 4,
  localparam int BW = (NUM_BR > 1) ? $clog2(NUM_BR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_req,
  input  logic              rsv_valid,
  input  logic [BW-1:0]     rsv_idx,
  input  logic              rsv_wrong,
  output logic              alloc_gnt,
  output logic [BW-1:0]     alloc_idx,
  output logic [NUM_BR-1:0] busy,
  output logic [NUM_BR-1:0] clr_bits,
  output logic [NUM_BR-1:0] miss_bit,
  output logic [NUM_BR-1:0] inherit_mask
);

  logic [NUM_BR-1:0] busy_q;
  logic [NUM_BR-1:0] dep_q [NUM_BR];   // older branches open at grant time
  logic [NUM_BR-1:0] hit_oh;
  logic [NUM_BR-1:0] younger;
  logic [NUM_BR-1:0] avail;
  logic [NUM_BR-1:0] gnt_oh;
  logic              any_free;
  rsv_kind_e         kind;

  // Decode the resolving slot; idle slots are ignored
  always_comb begin
    for (int j = 0; j < NUM_BR; j++) begin
      hit_oh[j] = rsv_valid && busy_q[j] && (rsv_idx == BW'(j));
    end
    if (hit_oh == '0)   kind = RSV_IDLE;
    else if (rsv_wrong) kind = RSV_MISS;
    else                kind = RSV_HIT;
  end

  // Younger branches were opened while the failed one was pending
  always_comb begin
    for (int j = 0; j < NUM_BR; j++) begin
      younger[j] = busy_q[j] && ((dep_q[j] & hit_oh) != '0);
    end
  end

  always_comb begin
    unique case (kind)
      RSV_HIT:  begin clr_bits = hit_oh;           miss_bit = '0;     end
      RSV_MISS: begin clr_bits = hit_oh | younger; miss_bit = hit_oh; end
      default:  begin clr_bits = '0;               miss_bit = '0;     end
    endcase
  end

  // Resolution first, then allocation from what is left
  assign avail        = ~busy_q | clr_bits;
  assign inherit_mask = busy_q & ~clr_bits;

  smt_prio_enc #(.W(NUM_BR)) u_free_pick (
    .req (avail),
    .any (any_free),
    .idx (alloc_idx)
  );

  assign alloc_gnt = alloc_req && any_free;

  always_comb begin
    gnt_oh = '0;
    for (int j = 0; j < NUM_BR; j++) begin
      gnt_oh[j] = alloc_gnt && (alloc_idx == BW'(j));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      for (int j = 0; j < NUM_BR; j++) dep_q[j] <= '0;
    end else begin
      busy_q <= (busy_q & ~clr_bits) | gnt_oh;
      for (int j = 0; j < NUM_BR; j++) begin
        if (gnt_oh[j]) dep_q[j] <= inherit_mask;
        else           dep_q[j] <= dep_q[j] & ~clr_bits;
      end
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/smt_entry_table.sv
module smt_entry_table #(
  parameter int NUM_BR  = 4,
  parameter int NUM_ENT = 8,
  localparam int EW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [EW-1:0]      wr_idx,
  input  logic [NUM_BR-1:0]  wr_mask,
  input  logic               rel_en,
  input  logic [EW-1:0]      rel_idx,
  input  logic [NUM_BR-1:0]  clr_bits,
  input  logic [NUM_BR-1:0]  miss_bit,
  input  logic [EW-1:0]      rd_idx,
  output logic [NUM_ENT-1:0] valid,
  output logic [NUM_ENT-1:0] kill,
  output logic [NUM_BR-1:0]  rd_mask
);

  logic [NUM_BR-1:0]  mask_q [NUM_ENT];
  logic [NUM_ENT-1:0] valid_q;
  logic [NUM_ENT-1:0] kill_q;
  logic [NUM_BR-1:0]  rd_q;
  logic [NUM_ENT-1:0] hit_e;
  logic [NUM_ENT-1:0] wr_e;
  logic [NUM_ENT-1:0] rel_e;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    assign wr_e[e]  = wr_en  && (wr_idx  == EW'(e));
    assign rel_e[e] = rel_en && (rel_idx == EW'(e));
    // Aborted: live, depends on the failed branch, not being overwritten
    assign hit_e[e] = valid_q[e] && ((mask_q[e] & miss_bit) != '0) && !wr_e[e];

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[e] <= 1'b0;
        kill_q[e]  <= 1'b0;
        mask_q[e]  <= '0;
      end else begin
        kill_q[e] <= hit_e[e];
        if (wr_e[e]) begin
          valid_q[e] <= 1'b1;
          mask_q[e]  <= wr_mask;
        end else begin
          if (hit_e[e] || rel_e[e]) valid_q[e] <= 1'b0;
          mask_q[e] <= mask_q[e] & ~clr_bits;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= mask_q[rd_idx];
  end

  assign valid   = valid_q;
  assign kill    = kill_q;
  assign rd_mask = rd_q;

endmodule

// File: rtl/spec_mask_tracker.sv
module spec_mask_tracker #(
  parameter int NUM_BR  = 4,
  parameter int NUM_ENT = 8,
  localparam int BW = (NUM_BR > 1) ? $clog2(NUM_BR) : 1,
  localparam int EW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               br_req,
  output logic               br_gnt,
  output logic [BW-1:0]      br_idx,
  input  logic               disp_valid,
  input  logic [EW-1:0]      disp_slot,
  output logic [NUM_BR-1:0]  disp_mask,
  input  logic               rsv_valid,
  input  logic [BW-1:0]      rsv_idx,
  input  logic               rsv_wrong,
  input  logic               rel_valid,
  input  logic [EW-1:0]      rel_slot,
  output logic [NUM_ENT-1:0] kill_vec,
  output logic [NUM_ENT-1:0] ent_valid,
  output logic [NUM_BR-1:0]  br_busy,
  input  logic [EW-1:0]      rd_slot,
  output logic [NUM_BR-1:0]  rd_mask
);

  logic [NUM_BR-1:0] clr_bits;
  logic [NUM_BR-1:0] miss_bit;

  smt_slot_pool #(.NUM_BR(NUM_BR)) u_pool (
    .clk          (clk),
    .rst          (rst),
    .alloc_req    (br_req),
    .rsv_valid    (rsv_valid),
    .rsv_idx      (rsv_idx),
    .rsv_wrong    (rsv_wrong),
    .alloc_gnt    (br_gnt),
    .alloc_idx    (br_idx),
    .busy         (br_busy),
    .clr_bits     (clr_bits),
    .miss_bit     (miss_bit),
    .inherit_mask (disp_mask)
  );

  smt_entry_table #(.NUM_BR(NUM_BR), .NUM_ENT(NUM_ENT)) u_table (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (disp_valid),
    .wr_idx   (disp_slot),
    .wr_mask  (disp_mask),
    .rel_en   (rel_valid),
    .rel_idx  (rel_slot),
    .clr_bits (clr_bits),
    .miss_bit (miss_bit),
    .rd_idx   (rd_slot),
    .valid    (ent_valid),
    .kill     (kill_vec),
    .rd_mask  (rd_mask)
  );

endmodule

// File: rtl/smt_checker.sv
module smt_checker #(
  parameter int NUM_BR  = 4,
  parameter int NUM_ENT = 8,
  localparam int BW = (NUM_BR > 1) ? $clog2(NUM_BR) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               br_req,
  input logic               br_gnt,
  input logic [BW-1:0]      br_idx,
  input logic               disp_valid,
  input logic [NUM_BR-1:0]  disp_mask,
  input logic               rsv_valid,
  input logic [BW-1:0]      rsv_idx,
  input logic               rsv_wrong,
  input logic [NUM_ENT-1:0] kill_vec,
  input logic [NUM_ENT-1:0] ent_valid,
  input logic [NUM_BR-1:0]  br_busy
);

  assert_grant_sets_busy_R2: assert property (@(posedge clk) disable iff (rst)
    br_gnt |=> ((br_busy >> $past(br_idx)) & NUM_BR'(1)) != '0);

  assert_stall_when_full_R3: assert property (@(posedge clk) disable iff (rst)
    (br_busy == '1 && !rsv_valid && br_req) |-> !br_gnt);

  assert_mask_within_busy_R4: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> (disp_mask & ~br_busy) == '0);

  assert_correct_frees_slot_R5: assert property (@(posedge clk) disable iff (rst)
    (rsv_valid && !rsv_wrong && ((br_busy >> rsv_idx) & NUM_BR'(1)) != '0
     && !(br_gnt && br_idx == rsv_idx))
    |=> ((br_busy >> $past(rsv_idx)) & NUM_BR'(1)) == '0);

  assert_kill_needs_miss_R6: assert property (@(posedge clk) disable iff (rst)
    (kill_vec != '0) |-> $past(rsv_valid && rsv_wrong));

  assert_kill_hits_live_R6: assert property (@(posedge clk) disable iff (rst)
    (kill_vec != '0) |-> (kill_vec & ~$past(ent_valid)) == '0);

  assert_killed_dropped_R6: assert property (@(posedge clk) disable iff (rst)
    (kill_vec & ent_valid) == '0);

  assert_idle_resolve_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (rsv_valid && ((br_busy >> rsv_idx) & NUM_BR'(1)) == '0) |=> kill_vec == '0);

endmodule

bind spec_mask_tracker smt_checker #(.NUM_BR(NUM_BR), .NUM_ENT(NUM_ENT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .br_req     (br_req),
  .br_gnt     (br_gnt),
  .br_idx     (br_idx),
  .disp_valid (disp_valid),
  .disp_mask  (disp_mask),
  .rsv_valid  (rsv_valid),
  .rsv_idx    (rsv_idx),
  .rsv_wrong  (rsv_wrong),
  .kill_vec   (kill_vec),
  .ent_valid  (ent_valid),
  .br_busy    (br_busy)
);

// File: tb/sim_spec_mask_tracker.sv
`timescale 1ns/1ps
module sim_spec_mask_tracker;

  logic       clk = 1'b0;
  logic       rst;
  logic       br_req, br_gnt;
  logic [1:0] br_idx;
  logic       disp_valid;
  logic [2:0] disp_slot;
  logic [3:0] disp_mask;
  logic       rsv_valid, rsv_wrong;
  logic [1:0] rsv_idx;
  logic       rel_valid;
  logic [2:0] rel_slot;
  logic [7:0] kill_vec, ent_valid;
  logic [3:0] br_busy;
  logic [2:0] rd_slot;
  logic [3:0] rd_mask;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  spec_mask_tracker u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    br_req = 0; disp_valid = 0; disp_slot = 0;
    rsv_valid = 0; rsv_idx = 0; rsv_wrong = 0;
    rel_valid = 0; rel_slot = 0;
  endtask

  // Advance to one unit after the next rising edge
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic read_mask(input logic [2:0] e, input logic [3:0] exp, input string tag);
    idle(); rd_slot = e; step();
    chk(tag, rd_mask, exp);
  endtask

  task automatic alloc(input logic dv, input logic [2:0] e, input logic [1:0] exp_idx,
                       input logic [3:0] exp_mask, input string tag);
    br_req = 1; disp_valid = dv; disp_slot = e; #1;
    chk({tag, " gnt"}, br_gnt, 1'b1);
    chk({tag, " idx"}, br_idx, exp_idx);
    chk({tag, " mask"}, disp_mask, exp_mask);
    step(); idle();
  endtask

  task automatic resolve(input logic [1:0] b, input logic wrong);
    rsv_valid = 1; rsv_idx = b; rsv_wrong = wrong; step(); idle();
  endtask

  task automatic t_reset();
    chk("R1 busy", br_busy, 4'h0);
    chk("R1 valid", ent_valid, 8'h00);
    chk("R1 kill", kill_vec, 8'h00);
    chk("R1 gnt", br_gnt, 1'b0);
  endtask

  task automatic t_fill();
    alloc(1, 3'd0, 2'd0, 4'h0, "R2 first");
    alloc(1, 3'd1, 2'd1, 4'h1, "R2 second");
    alloc(1, 3'd2, 2'd2, 4'h3, "R4 third");
    alloc(1, 3'd3, 2'd3, 4'h7, "R4 fourth");
    disp_valid = 1; disp_slot = 3'd4; #1;
    chk("R4 plain mask", disp_mask, 4'hF);
    step(); idle();
    br_req = 1; #1;
    chk("R3 stall", br_gnt, 1'b0);
    step(); idle();
    chk("R3 busy kept", br_busy, 4'hF);
    chk("R2 valid set", ent_valid, 8'h1F);
    read_mask(3'd4, 4'hF, "R11 entry4");
    read_mask(3'd2, 4'h3, "R11 entry2");
  endtask

  task automatic t_correct();
    resolve(2'd1, 1'b0);
    chk("R5 busy", br_busy, 4'hD);
    chk("R5 no kill", kill_vec, 8'h00);
    read_mask(3'd4, 4'hD, "R5 entry4");
    read_mask(3'd3, 4'h5, "R5 entry3");
  endtask

  task automatic t_wrong();
    resolve(2'd2, 1'b1);
    chk("R6 kill", kill_vec, 8'h18);
    chk("R6 valid", ent_valid, 8'h07);
    chk("R7 busy", br_busy, 4'h1);
    step();
    chk("R6 pulse", kill_vec, 8'h00);
  endtask

  task automatic t_same_cycle();
    alloc(0, 3'd0, 2'd1, 4'h1, "R2 refill1");
    alloc(0, 3'd0, 2'd2, 4'h3, "R2 refill2");
    alloc(0, 3'd0, 2'd3, 4'h7, "R2 refill3");
    br_req = 1; rsv_valid = 1; rsv_idx = 2'd2; rsv_wrong = 0;
    disp_valid = 1; disp_slot = 3'd5; #1;
    chk("R8 gnt", br_gnt, 1'b1);
    chk("R8 idx", br_idx, 2'd2);
    chk("R4 mask excl", disp_mask, 4'hB);
    step(); idle();
    chk("R8 busy", br_busy, 4'hF);
    read_mask(3'd5, 4'hB, "R4 entry5");
  endtask

  task automatic t_idle_resolve();
    resolve(2'd3, 1'b1);
    chk("R6 kill e5", kill_vec, 8'h20);
    chk("R7 busy", br_busy, 4'h3);
    chk("R6 valid", ent_valid, 8'h07);
    resolve(2'd3, 1'b1);
    chk("R9 kill", kill_vec, 8'h00);
    chk("R9 busy", br_busy, 4'h3);
    resolve(2'd2, 1'b0);
    chk("R9 busy2", br_busy, 4'h3);
    read_mask(3'd1, 4'h1, "R9 entry1");
  endtask

  task automatic t_release();
    rel_valid = 1; rel_slot = 3'd1; step(); idle();
    chk("R10 valid", ent_valid, 8'h05);
    resolve(2'd0, 1'b1);
    chk("R10 kill", kill_vec, 8'h04);
    chk("R7 busy", br_busy, 4'h0);
    chk("R6 valid", ent_valid, 8'h01);
    read_mask(3'd0, 4'h0, "R11 entry0");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(); rd_slot = 0; rst = 1;
    repeat (3) @(posedge clk);
    #1; rst = 0;
    t_reset();
    t_fill();
    t_correct();
    t_wrong();
    t_same_cycle();
    t_idle_resolve();
    t_release();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule